// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Processor Core

This block is a small processor that finishes one instruction in every clock cycle. It fetches a 32-bit word from its own instruction memory at the program counter. It decodes that word, reads up to two of its 32 general registers, and computes a result or an address. On the same rising edge it updates the register file, the data memory and the program counter. The instruction set is a compact subset of a classic three-format load/store architecture. It covers register arithmetic, immediate arithmetic and logic, word loads and stores, two conditional branches and three kinds of jump.

Both memories are word arrays held inside the core. A test port gives access to them. While the port enable is high, the core is frozen and the port can write or read either memory one word at a time. A testbench uses it to place a program and its data, to release the core for a chosen number of cycles, and then to read back what the program stored.

Top module: `tiny_risc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 at the next rising edge and clears all 32 registers to zero.
- R2: While `tpEn` is 1, the core executes nothing. The program counter holds, and neither registers nor data memory change. `tpSel`=0 selects instruction memory and `tpSel`=1 selects data memory. `tpWe`=1 writes `tpWdata` to word `tpAddr` at the rising edge, and `tpRdata` shows word `tpAddr` of the selected memory combinationally.
- R3: Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0], imm[15:0] and target[25:0]. With op 0, funct 0x20 gives add, 0x22 gives sub and 0x2A gives slt, each writing rd from rs and rt. slt writes 1 when rs < rt as signed values and 0 otherwise.
- R4: addi (op 8) writes rs + sign-extended imm into rt. slti (op 10) writes 1 into rt when rs < sign-extended imm as signed values, and 0 otherwise.
- R5: andi (op 12) and ori (op 13) combine rs with the zero-extended imm into rt. lui (op 15) writes imm into rt[31:16] and zeros into rt[15:0].
- R6: lw (op 35) loads into rt the data word at byte address rs + sign-extended imm. sw (op 43) stores rt there and writes no register. The word index is the address bits above bit 1.
- R7: Register 0 always reads as zero, and a write aimed at it is discarded.
- R8: beq (op 4) and bne (op 5) compare rs with rt. When taken, the next PC is PC+4 + (sign-extended imm × 4). Otherwise it is PC+4.
- R9: j (op 2) and jal (op 3) set PC to {PC[31:28], target, 2'b00}. jal also writes PC+4 into register 31.
- R10: jr (op 0, funct 0x08) sets PC to the value of rs.
- R11: Any other opcode, or op 0 with any other funct, changes no register or memory and advances PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of PC and registers |
| tpEn | input | 1 | Test port enable; freezes the core while high |
| tpSel | input | 1 | Test port target: 0 instruction memory, 1 data memory |
| tpWe | input | 1 | Test port write strobe |
| tpAddr | input | TP_AW | Test port word address |
| tpWdata | input | 32 | Test port write data |
| tpRdata | output | 32 | Test port read data (combinational) |
| pcOut | output | 32 | Current program counter |

## Verification
Every instruction completes in the cycle in which it is fetched. Its register write, its store and the new program counter all appear just after the rising edge that ends that cycle, so nothing in the pipeline adds a delay. The bench drives all inputs on falling edges. Lowering `tpEn` for exactly n falling-to-falling intervals therefore retires exactly n instructions. The bench then raises `tpEn` and reads data memory through the combinational test port one time step after a falling edge. Checks on the program counter are sampled the same way, half a cycle after the edge that updated it.

// File: rtl/tiny_risc_pkg.sv
package tiny_risc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_SLT = 6'h2A;
  localparam logic [5:0] FN_JR  = 6'h08;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASSB
  } aluOp_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } immKind_e;

  typedef enum logic [1:0] {
    DST_RT, DST_RD, DST_LINK
  } dstSel_e;

  typedef struct packed {
    logic     regWrite;
    dstSel_e  dstSel;
    logic     useImm;
    immKind_e immKind;
    aluOp_e   aluOp;
    logic     memWrite;
    logic     memToReg;
    logic     linkData;
    logic     brEq;
    logic     brNe;
    logic     jmp;
    logic     jmpReg;
  } ctrl_t;

endpackage

// File: rtl/tiny_risc_ctrl.sv
module tiny_risc_ctrl
  import tiny_risc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl          = '0;
    ctl.dstSel   = DST_RT;
    ctl.immKind  = IMM_SIGN;
    ctl.aluOp    = ALU_ADD;
    unique case (op)
      OP_RTYPE: begin
        ctl.dstSel = DST_RD;
        case (funct)
          FN_ADD: begin ctl.regWrite = 1'b1; ctl.aluOp = ALU_ADD; end
          FN_SUB: begin ctl.regWrite = 1'b1; ctl.aluOp = ALU_SUB; end
          FN_SLT: begin ctl.regWrite = 1'b1; ctl.aluOp = ALU_SLT; end
          FN_JR:  ctl.jmpReg = 1'b1;
          default: ;
        endcase
      end
      OP_ADDI: begin
        ctl.regWrite = 1'b1; ctl.useImm = 1'b1; ctl.aluOp = ALU_ADD;
      end
      OP_SLTI: begin
        ctl.regWrite = 1'b1; ctl.useImm = 1'b1; ctl.aluOp = ALU_SLT;
      end
      OP_ANDI: begin
        ctl.regWrite = 1'b1; ctl.useImm = 1'b1;
        ctl.immKind  = IMM_ZERO; ctl.aluOp = ALU_AND;
      end
      OP_ORI: begin
        ctl.regWrite = 1'b1; ctl.useImm = 1'b1;
        ctl.immKind  = IMM_ZERO; ctl.aluOp = ALU_OR;
      end
      OP_LUI: begin
        ctl.regWrite = 1'b1; ctl.useImm = 1'b1;
        ctl.immKind  = IMM_UPPER; ctl.aluOp = ALU_PASSB;
      end
      OP_LW: begin
        ctl.regWrite = 1'b1; ctl.useImm = 1'b1; ctl.memToReg = 1'b1;
      end
      OP_SW: begin
        ctl.useImm = 1'b1; ctl.memWrite = 1'b1;
      end
      OP_BEQ: ctl.brEq = 1'b1;
      OP_BNE: ctl.brNe = 1'b1;
      OP_J:   ctl.jmp  = 1'b1;
      OP_JAL: begin
        ctl.jmp = 1'b1; ctl.regWrite = 1'b1;
        ctl.dstSel = DST_LINK; ctl.linkData = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tiny_risc_regfile.sv
module tiny_risc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  rdAddrA,
  input  logic [RAW-1:0]  rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [RAW-1:0]  wrAddr,
  input  logic [XLEN-1:0] wrData
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/tiny_risc_alu.sv
module tiny_risc_alu
  import tiny_risc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  aluOp_e          aluOp,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);

  always_comb begin
    unique case (aluOp)
      ALU_ADD:   result = opA + opB;
      ALU_SUB:   result = opA - opB;
      ALU_SLT:   result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      ALU_AND:   result = opA & opB;
      ALU_OR:    result = opA | opB;
      ALU_PASSB: result = opB;
      default:   result = '0;
    endcase
  end

endmodule

// File: rtl/tiny_risc_datapath.sv
module tiny_risc_datapath
  import tiny_risc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int TP_AW   = 6,
  localparam int XLEN   = 32,
  localparam int IWORDS = 1 << IMEM_AW,
  localparam int DWORDS = 1 << DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctl,
  output logic [XLEN-1:0]  instr,
  output logic [XLEN-1:0]  pcOut,
  input  logic             tpEn,
  input  logic             tpSel,
  input  logic             tpWe,
  input  logic [TP_AW-1:0] tpAddr,
  input  logic [XLEN-1:0]  tpWdata,
  output logic [XLEN-1:0]  tpRdata
);

  logic [XLEN-1:0] imem [IWORDS];
  logic [XLEN-1:0] dmem [DWORDS];

  logic [XLEN-1:0] pcQ, pcPlus4, branchTgt, jumpTgt, pcNext;
  logic [XLEN-1:0] rsVal, rtVal, immVal, aluB, aluY, loadWord, wbData;
  logic [4:0]      wbAddr;
  logic            regWe, takeBranch;
  logic [DMEM_AW-1:0] dIdx;

  assign instr = imem[pcQ[IMEM_AW+1:2]];
  assign pcOut = pcQ;

  always_comb begin
    unique case (ctl.immKind)
      IMM_ZERO:  immVal = {16'h0000, instr[15:0]};
      IMM_UPPER: immVal = {instr[15:0], 16'h0000};
      default:   immVal = {{16{instr[15]}}, instr[15:0]};
    endcase
  end

  tiny_risc_regfile #(.XLEN(XLEN), .NREGS(32)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (instr[25:21]),
    .rdAddrB (instr[20:16]),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (regWe),
    .wrAddr  (wbAddr),
    .wrData  (wbData)
  );

  assign aluB = ctl.useImm ? immVal : rtVal;

  tiny_risc_alu #(.XLEN(XLEN)) u_alu (
    .aluOp  (ctl.aluOp),
    .opA    (rsVal),
    .opB    (aluB),
    .result (aluY)
  );

  assign dIdx     = aluY[DMEM_AW+1:2];
  assign loadWord = dmem[dIdx];

  always_comb begin
    unique case (ctl.dstSel)
      DST_RD:   wbAddr = instr[15:11];
      DST_LINK: wbAddr = 5'd31;
      default:  wbAddr = instr[20:16];
    endcase
  end

  assign wbData = ctl.linkData ? pcPlus4 : (ctl.memToReg ? loadWord : aluY);
  assign regWe  = ctl.regWrite && !tpEn;

  assign pcPlus4    = pcQ + 32'd4;
  assign branchTgt  = pcPlus4 + {immVal[XLEN-3:0], 2'b00};
  assign jumpTgt    = {pcQ[31:28], instr[25:0], 2'b00};
  assign takeBranch = (ctl.brEq && (rsVal == rtVal)) || (ctl.brNe && (rsVal != rtVal));

  always_comb begin
    if (ctl.jmpReg)      pcNext = rsVal;
    else if (ctl.jmp)    pcNext = jumpTgt;
    else if (takeBranch) pcNext = branchTgt;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst)        pcQ <= '0;
    else if (!tpEn) pcQ <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (tpEn && tpWe && !tpSel) imem[tpAddr[IMEM_AW-1:0]] <= tpWdata;
  end

  always_ff @(posedge clk) begin
    if (tpEn) begin
      if (tpWe && tpSel) dmem[tpAddr[DMEM_AW-1:0]] <= tpWdata;
    end else if (!rst && ctl.memWrite) begin
      dmem[dIdx] <= rtVal;
    end
  end

  assign tpRdata = tpSel ? dmem[tpAddr[DMEM_AW-1:0]] : imem[tpAddr[IMEM_AW-1:0]];

endmodule

// File: rtl/tiny_risc_core.sv
module tiny_risc_core
  import tiny_risc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int TP_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tpEn,
  input  logic             tpSel,
  input  logic             tpWe,
  input  logic [TP_AW-1:0] tpAddr,
  input  logic [31:0]      tpWdata,
  output logic [31:0]      tpRdata,
  output logic [31:0]      pcOut
);

  ctrl_t       ctl;
  logic [31:0] instr;

  tiny_risc_ctrl u_ctrl (
    .op    (instr[31:26]),
    .funct (instr[5:0]),
    .ctl   (ctl)
  );

  tiny_risc_datapath #(
    .IMEM_AW (IMEM_AW),
    .DMEM_AW (DMEM_AW),
    .TP_AW   (TP_AW)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .instr   (instr),
    .pcOut   (pcOut),
    .tpEn    (tpEn),
    .tpSel   (tpSel),
    .tpWe    (tpWe),
    .tpAddr  (tpAddr),
    .tpWdata (tpWdata),
    .tpRdata (tpRdata)
  );

endmodule

// File: rtl/tiny_risc_checker.sv
module tiny_risc_checker (
  input logic        clk,
  input logic        rst,
  input logic        tpEn,
  input logic [31:0] pcOut,
  input logic [31:0] instr,
  input logic        regWrite,
  input logic        memWrite
);

  logic        rstD;
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic        knownInstr;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    case (opc)
      6'd0:    knownInstr = (fn == 6'h20) || (fn == 6'h22) || (fn == 6'h2A) || (fn == 6'h08);
      6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd10, 6'd12, 6'd13, 6'd15, 6'd35, 6'd43:
               knownInstr = 1'b1;
      default: knownInstr = 1'b0;
    endcase
  end

  always_ff @(posedge clk) rstD <= rst;

  // R1: the cycle after reset was sampled, the PC reads zero
  always_ff @(posedge clk) begin
    if (rstD === 1'b1) begin
      assert_pc_cleared_R1: assert (pcOut == 32'd0);
    end
  end

  assert_hold_pc_R2: assert property (@(posedge clk) disable iff (rst)
    tpEn |=> $stable(pcOut));

  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (!tpEn && opc == 6'd43) |-> (memWrite && !regWrite));

  assert_self_branch_R8: assert property (@(posedge clk) disable iff (rst)
    (!tpEn && opc == 6'd4 && instr[25:16] == 10'd0) |=>
      pcOut == $past(pcOut) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
    (!tpEn && opc == 6'd2) |=>
      pcOut == {$past(pcOut[31:28]), $past(instr[25:0]), 2'b00});

  assert_unknown_nop_R11: assert property (@(posedge clk) disable iff (rst)
    (!tpEn && !knownInstr) |=> (pcOut == $past(pcOut) + 32'd4));

  assert_unknown_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (!tpEn && !knownInstr) |-> (!regWrite && !memWrite));

endmodule

bind tiny_risc_core tiny_risc_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .tpEn     (tpEn),
  .pcOut    (pcOut),
  .instr    (instr),
  .regWrite (ctl.regWrite),
  .memWrite (ctl.memWrite)
);

// File: tb/tiny_risc_core_bench.sv
module tiny_risc_core_bench;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tpEn = 1'b1;
  logic          tpSel = 1'b0;
  logic          tpWe = 1'b0;
  logic [AW-1:0] tpAddr = '0;
  logic [31:0]   tpWdata = '0;
  logic [31:0]   tpRdata;
  logic [31:0]   pcOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tiny_risc_core #(.IMEM_AW(AW), .DMEM_AW(AW)) u_tiny_risc_core (
    .clk(clk), .rst(rst), .tpEn(tpEn), .tpSel(tpSel), .tpWe(tpWe),
    .tpAddr(tpAddr), .tpWdata(tpWdata), .tpRdata(tpRdata), .pcOut(pcOut)
  );

  localparam logic [31:0] HALT = {6'd4, 5'd0, 5'd0, 16'hFFFF};

  function automatic logic [31:0] rEnc(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] iEnc(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] jEnc(logic [5:0] op, int tgt);
    return {op, tgt[25:0]};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic resetCore();
    @(negedge clk);
    tpEn = 1'b1; tpWe = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tpWrite(bit sel, int addr, logic [31:0] data);
    tpEn = 1'b1; tpSel = sel; tpWe = 1'b1;
    tpAddr = addr[AW-1:0]; tpWdata = data;
    @(negedge clk);
    tpWe = 1'b0;
  endtask

  task automatic tpRead(bit sel, int addr, output logic [31:0] data);
    tpWe = 1'b0; tpSel = sel; tpAddr = addr[AW-1:0];
    #1 data = tpRdata;
  endtask

  task automatic run(int n);
    tpEn = 1'b0;
    repeat (n) @(negedge clk);
    tpEn = 1'b1;
  endtask

  task automatic testResetState();
    logic [31:0] w;
    repeat (2) @(negedge clk);
    check("R1", "pc during reset", pcOut, 32'd0);
    rst = 1'b0;
    tpWrite(1, 5, 32'h1357_9BDF);
    tpWrite(0, 7, 32'h2468_ACE0);
    tpRead(1, 5, w); check("R2", "data port readback", w, 32'h1357_9BDF);
    tpRead(0, 7, w); check("R2", "instr port readback", w, 32'h2468_ACE0);
  endtask

  task automatic testArith();
    logic [31:0] w;
    logic [31:0] exp [11];
    resetCore();
    tpWrite(0, 0,  iEnc(6'd8, 0, 1, 7));
    tpWrite(0, 1,  iEnc(6'd8, 0, 2, -3));
    tpWrite(0, 2,  rEnc(1, 2, 3, 6'h20));
    tpWrite(0, 3,  rEnc(2, 1, 4, 6'h22));
    tpWrite(0, 4,  rEnc(2, 1, 5, 6'h2A));
    tpWrite(0, 5,  rEnc(1, 2, 6, 6'h2A));
    tpWrite(0, 6,  iEnc(6'd10, 2, 7, -2));
    tpWrite(0, 7,  iEnc(6'd12, 2, 8, 16'hFF00));
    tpWrite(0, 8,  iEnc(6'd13, 0, 9, 16'h8001));
    tpWrite(0, 9,  iEnc(6'd15, 0, 10, 16'hABCD));
    tpWrite(0, 10, iEnc(6'd8, 0, 0, 5));
    for (int k = 0; k <= 10; k++) tpWrite(0, 11 + k, iEnc(6'd43, 0, k, 4 * k));
    tpWrite(0, 22, HALT);
    run(30);
    exp = '{32'd0, 32'd7, 32'hFFFF_FFFD, 32'd4, 32'hFFFF_FFF6, 32'd1, 32'd0,
            32'd1, 32'h0000_FF00, 32'h0000_8001, 32'hABCD_0000};
    tpRead(1, 0, w);  check("R7", "r0 after write to r0", w, exp[0]);
    tpRead(1, 1, w);  check("R4", "addi positive", w, exp[1]);
    tpRead(1, 2, w);  check("R4", "addi negative sign-extended", w, exp[2]);
    tpRead(1, 3, w);  check("R3", "add", w, exp[3]);
    tpRead(1, 4, w);  check("R3", "sub", w, exp[4]);
    tpRead(1, 5, w);  check("R3", "slt signed true", w, exp[5]);
    tpRead(1, 6, w);  check("R3", "slt signed false", w, exp[6]);
    tpRead(1, 7, w);  check("R4", "slti signed", w, exp[7]);
    tpRead(1, 8, w);  check("R5", "andi zero-extended", w, exp[8]);
    tpRead(1, 9, w);  check("R5", "ori zero-extended", w, exp[9]);
    tpRead(1, 10, w); check("R5", "lui", w, exp[10]);
  endtask

  task automatic testMemory();
    logic [31:0] w;
    resetCore();
    tpWrite(1, 16, 32'hCAFE_F00D);
    tpWrite(0, 0, iEnc(6'd8, 0, 1, 16'h0040));
    tpWrite(0, 1, iEnc(6'd8, 0, 2, 16'h1234));
    tpWrite(0, 2, iEnc(6'd43, 1, 2, -8));
    tpWrite(0, 3, iEnc(6'd35, 1, 3, -8));
    tpWrite(0, 4, iEnc(6'd8, 3, 4, 1));
    tpWrite(0, 5, iEnc(6'd43, 1, 4, 4));
    tpWrite(0, 6, iEnc(6'd35, 1, 5, 0));
    tpWrite(0, 7, iEnc(6'd43, 1, 5, 8));
    tpWrite(0, 8, HALT);
    run(15);
    tpRead(1, 14, w); check("R6", "sw negative offset", w, 32'h0000_1234);
    tpRead(1, 17, w); check("R6", "lw then use", w, 32'h0000_1235);
    tpRead(1, 18, w); check("R6", "lw of preloaded word", w, 32'hCAFE_F00D);
  endtask

  task automatic testBranch();
    logic [31:0] w;
    resetCore();
    tpWrite(0, 0,  iEnc(6'd8, 0, 1, 5));
    tpWrite(0, 1,  iEnc(6'd8, 0, 2, 5));
    tpWrite(0, 2,  iEnc(6'd4, 1, 2, 2));
    tpWrite(0, 3,  iEnc(6'd8, 0, 3, 1));
    tpWrite(0, 4,  iEnc(6'd8, 0, 4, 1));
    tpWrite(0, 5,  iEnc(6'd5, 1, 2, 1));
    tpWrite(0, 6,  iEnc(6'd8, 0, 5, 9));
    tpWrite(0, 7,  iEnc(6'd5, 1, 0, 1));
    tpWrite(0, 8,  iEnc(6'd8, 0, 6, 1));
    tpWrite(0, 9,  iEnc(6'd8, 7, 7, 1));
    tpWrite(0, 10, iEnc(6'd10, 7, 8, 3));
    tpWrite(0, 11, iEnc(6'd5, 8, 0, -3));
    for (int k = 3; k <= 7; k++) tpWrite(0, 9 + k, iEnc(6'd43, 0, k, 4 * k));
    tpWrite(0, 17, HALT);
    run(30);
    tpRead(1, 3, w); check("R8", "beq taken skips", w, 32'd0);
    tpRead(1, 4, w); check("R8", "beq taken skips second", w, 32'd0);
    tpRead(1, 5, w); check("R8", "bne not taken falls through", w, 32'd9);
    tpRead(1, 6, w); check("R8", "bne taken skips", w, 32'd0);
    tpRead(1, 7, w); check("R8", "backward bne loop count", w, 32'd3);
    check("R8", "halt pc", pcOut, 32'd68);
  endtask

  task automatic testJump();
    logic [31:0] w;
    resetCore();
    tpWrite(0, 0,  jEnc(6'd3, 5));
    tpWrite(0, 1,  iEnc(6'd8, 0, 2, 16'h0077));
    tpWrite(0, 2,  jEnc(6'd2, 8));
    tpWrite(0, 3,  iEnc(6'd8, 0, 3, 1));
    tpWrite(0, 4,  HALT);
    tpWrite(0, 5,  iEnc(6'd8, 0, 1, 16'h0011));
    tpWrite(0, 6,  rEnc(31, 0, 0, 6'h08));
    tpWrite(0, 7,  iEnc(6'd8, 0, 4, 1));
    tpWrite(0, 8,  iEnc(6'd43, 0, 31, 0));
    tpWrite(0, 9,  iEnc(6'd43, 0, 1, 4));
    tpWrite(0, 10, iEnc(6'd43, 0, 2, 8));
    tpWrite(0, 11, iEnc(6'd43, 0, 3, 12));
    tpWrite(0, 12, iEnc(6'd43, 0, 4, 16));
    tpWrite(0, 13, HALT);
    run(1);
    check("R9", "jal target pc", pcOut, 32'h0000_0014);
    run(19);
    tpRead(1, 0, w); check("R9", "jal link value in r31", w, 32'd4);
    tpRead(1, 1, w); check("R9", "jal reached target", w, 32'h11);
    tpRead(1, 2, w); check("R10", "jr returned to link", w, 32'h77);
    tpRead(1, 3, w); check("R9", "j skipped instruction", w, 32'd0);
    tpRead(1, 4, w); check("R10", "jr skipped instruction", w, 32'd0);
    check("R9", "final pc", pcOut, 32'h0000_0034);
  endtask

  task automatic testHoldAndUnknown();
    logic [31:0] w;
    resetCore();
    tpWrite(1, 0, 32'hDEAD_BEEF);
    tpWrite(0, 0, iEnc(6'd8, 0, 1, 16'h0055));
    tpWrite(0, 1, 32'hFC21_0005);
    tpWrite(0, 2, rEnc(1, 1, 1, 6'h3F));
    tpWrite(0, 3, iEnc(6'd43, 0, 1, 0));
    tpWrite(0, 4, HALT);
    run(3);
    check("R11", "pc after two unknown words", pcOut, 32'd12);
    repeat (5) @(negedge clk);
    check("R2", "pc held while port enabled", pcOut, 32'd12);
    tpRead(1, 0, w); check("R2", "store held while port enabled", w, 32'hDEAD_BEEF);
    tpRead(0, 1, w); check("R2", "instr memory readback", w, 32'hFC21_0005);
    run(6);
    tpRead(1, 0, w); check("R11", "unknown words left r1 intact", w, 32'h55);
    check("R11", "halt pc", pcOut, 32'h10);
  endtask

  task automatic testResetClears();
    logic [31:0] w;
    resetCore();
    tpWrite(0, 0, iEnc(6'd43, 0, 31, 0));
    tpWrite(0, 1, iEnc(6'd43, 0, 1, 4));
    tpWrite(0, 2, iEnc(6'd43, 0, 2, 8));
    tpWrite(0, 3, HALT);
    run(8);
    tpRead(1, 0, w); check("R1", "r31 cleared by reset", w, 32'd0);
    tpRead(1, 1, w); check("R1", "r1 cleared by reset", w, 32'd0);
    tpRead(1, 2, w); check("R1", "r2 cleared by reset", w, 32'd0);
  endtask

  initial begin
    testResetState();
    testArith();
    testMemory();
    testBranch();
    testJump();
    testHoldAndUnknown();
    testResetClears();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule